// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is an I2C bus master that software steers one bus step at a time. It offers a small register file: a mode register, a control register, transmit and receive data registers, a status register and a clock divider. Software writes the start bit, and the controller produces a start condition and then sends the transmit register as the address byte. It then parks the bus. It holds SCL low, leaves SDA released and pulses an interrupt.

From that parked state software reads the status and the received byte, loads the next byte and writes one control request. The request can be another data byte, in the direction chosen by the mode register, a repeated start followed by a new address byte, or a stop condition that frees the bus. SCL and SDA are open-drain. The block only asserts output enables that pull a line low. It reads SDA back and shifts in every bit it sees on the bus, so a transmitted byte can be compared with what actually appeared on the wire.

Top module: `i2c_byte_master`

Register map (`addr`):
- 0 holds the mode. Bit 0 is the direction (1 = receive). Bit 1 is the level the master drives on the acknowledge clock of a receive byte (0 = ACK).
- 1 holds the control requests, which read as 0. Bit 0 is start, bit 1 is stop and bit 2 is restart.
- 2 holds the transmit data.
- 3 holds the receive data, which is read-only.
- 4 holds the status. Bit 0 is the error flag, cleared by writing 1. Bit 1 is the acknowledge bit last sampled. Bit 2 is busy. Bit 3 is the parked state.
- 5 holds the divider.

## Requirements
- R1: After reset, status reads 0, the receive register reads 0, the divider reads DIV_RST, irq is low, and neither bus line is pulled.
- R2: A start request written while idle makes SDA fall while SCL is high. The master then clocks out the transmit register and an acknowledge clock, which is nine SCL rising edges.
- R3: Entering the parked state raises irq for exactly one clock. SCL then stays pulled low, and status reads 0x0C, until a valid request is written.
- R4: Transmit bytes appear on SDA most significant bit first. The receive register afterwards holds the eight values sampled on SDA at the SCL rising edges.
- R5: Status bit 1 holds the SDA level sampled at the ninth SCL rising edge of the last byte.
- R6: The error flag is set by a NACK on a transmit byte. It is also set when a transmit data bit that the master releases reads back low. It stays set through writes of 0 and is cleared only by writing 1 to status bit 0.
- R7: In receive mode the master releases SDA for eight bits and shifts them MSB first into the receive register. On the ninth clock it drives mode bit 1.
- R8: A stop request makes SDA rise while SCL is high. Afterwards busy reads 0 and both lines are released.
- R9: A restart request produces a repeated start (SDA falls while SCL is high). The master then sends the transmit register and parks again.
- R10: Control requests written while a bus step is in progress are ignored. Stop and restart requests written while idle are also ignored.
- R11: Each quarter of an SCL period lasts DIV+1 clocks, so SCL stays high for 2*(DIV+1) clocks per bit.
- R12: The mode register is sampled when the start request is accepted. A mode write during the byte does not affect that byte.
- R13: When several request bits are written together, stop wins over restart, and restart wins over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |
| irq | output | 1 | One-clock pulse on entering the parked state |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that `sda_i` is the wired-AND of the master's own drive and any slave pull-down. This matters because the error and read-back logic only means something when the bus is reflected faithfully. The bench models exactly that open-drain line. Its slave model changes its pull-down only after SCL falls, so SDA never moves while SCL is high during a byte. The bench writes requests from idle or from the parked state, plus deliberate writes in the middle of a byte to exercise the ignore rule. It never holds SCL low, because the block does not support clock stretching.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter logic [7:0] DIV_RST = 8'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_TXD = 3'd2,
                         A_RXD = 3'd3, A_STAT = 3'd4, A_DIV = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_WAIT, S_RSTART, S_STOP} st_t;

  st_t        st;
  logic [1:0] mode_q, ph;
  logic [7:0] txd_q, rxd_q, div_q, qcnt, sh_q;
  logic [3:0] bitc;
  logic       err_q, ack_q, rx_q, ackv_q;

  wire ctl_wr  = wr_en && addr == A_CTRL;
  wire req_sp  = ctl_wr && wdata[1];
  wire req_rs  = ctl_wr && wdata[2] && !wdata[1];
  wire req_st  = ctl_wr && wdata[0] && !wdata[1] && !wdata[2];
  wire err_clr = wr_en && addr == A_STAT && wdata[0];
  wire in_wait = st == S_WAIT;
  wire busy    = st != S_IDLE;
  wire active  = busy && !in_wait;
  wire tick    = qcnt == 8'd0;
  wire samp    = st == S_BYTE && tick && ph == 2'd1;
  wire bit_end = tick && ph == 2'd3;
  wire ackbit  = bitc == 4'd8;
  wire bit_val = ackbit ? (!rx_q || ackv_q) : (rx_q || sh_q[7]);

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START:  sda_oe = ph[1];
      S_BYTE:   begin scl_oe = !ph[1]; sda_oe = !bit_val; end
      S_WAIT:   scl_oe = 1'b1;
      S_RSTART: begin scl_oe = ph == 2'd0; sda_oe = ph[1]; end
      S_STOP:   begin scl_oe = ph == 2'd0; sda_oe = !ph[1]; end
      default:  ;
    endcase
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = {6'd0, mode_q};
      A_TXD:   rdata = txd_q;
      A_RXD:   rdata = rxd_q;
      A_STAT:  rdata = {4'd0, in_wait, busy, ack_q, err_q};
      A_DIV:   rdata = div_q;
      default: rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= '0;
      txd_q <= '0;
      rxd_q <= '0;
      div_q <= DIV_RST;
      qcnt <= DIV_RST;
      sh_q <= '0;
      ph <= '0;
      bitc <= '0;
      err_q <= 1'b0;
      ack_q <= 1'b0;
      rx_q <= 1'b0;
      ackv_q <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_en && addr == A_MODE) mode_q <= wdata[1:0];
      if (wr_en && addr == A_TXD) txd_q <= wdata;
      if (wr_en && addr == A_DIV) div_q <= wdata;
      if (err_clr) err_q <= 1'b0;
      qcnt <= (!active || tick) ? div_q : qcnt - 8'd1;
      if (active && tick) ph <= ph + 2'd1;
      if (samp) begin
        if (ackbit) begin
          ack_q <= sda_i;
          if (!rx_q && sda_i) err_q <= 1'b1;
        end else begin
          rxd_q <= {rxd_q[6:0], sda_i};
          if (!rx_q && sh_q[7] && !sda_i) err_q <= 1'b1;
        end
      end
      case (st)
        S_IDLE: if (req_st) begin
          st <= S_START;
          ph <= '0;
          rx_q <= 1'b0;
        end
        S_WAIT: begin
          ph <= '0;
          bitc <= '0;
          if (req_sp) st <= S_STOP;
          else if (req_rs) begin
            st <= S_RSTART;
            rx_q <= 1'b0;
          end else if (req_st) begin
            st <= S_BYTE;
            sh_q <= txd_q;
            rx_q <= mode_q[0];
            ackv_q <= mode_q[1];
          end
        end
        S_START, S_RSTART: if (bit_end) begin
          st <= S_BYTE;
          sh_q <= txd_q;
          bitc <= '0;
        end
        S_BYTE: if (bit_end) begin
          sh_q <= {sh_q[6:0], 1'b0};
          bitc <= bitc + 4'd1;
          if (ackbit) begin
            st <= S_WAIT;
            irq <= 1'b1;
          end
        end
        S_STOP: if (bit_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R3
  AST_IRQ_ON_PARK: assert property (@(posedge clk) disable iff (!rst_n) $rose(in_wait) |-> irq); // R3
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (in_wait && !ctl_wr) |=> in_wait); // R3
  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && ph[1] && $past(st == S_BYTE && ph[1])) |-> $stable(sda_oe)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_q && !err_clr) |=> err_q); // R6
  AST_MIDBYTE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && ctl_wr && !(bit_end && ackbit)) |=> st == S_BYTE); // R10
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  localparam int CLK_P = 10;
  localparam logic [2:0] R_MODE = 3'd0, R_CTRL = 3'd1, R_TXD = 3'd2,
                         R_RXD = 3'd3, R_STAT = 3'd4, R_DIV = 3'd5;
  localparam logic [8:0] ACK_PAT = 9'h100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq, scl_oe, sda_oe;

  logic [8:0] sl_pat = '0;
  int         sl_idx = 99;
  wire pull  = (sl_idx >= 0 && sl_idx <= 8) ? sl_pat[sl_idx[3:0]] : 1'b0;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | pull);

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sda_i(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #(CLK_P / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int start_cnt = 0, stop_cnt = 0, mon_n = 0, irq_cnt = 0, hi_run = 0, last_hi = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [8:0] mon_sh = '0;

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (p_scl && scl_l && p_sda && !sda_l) start_cnt++;
    if (p_scl && scl_l && !p_sda && sda_l) stop_cnt++;
    if (!p_scl && scl_l) begin mon_sh = {mon_sh[7:0], sda_l}; mon_n++; end
    if (scl_l) hi_run++;
    else begin
      if (p_scl) last_hi = hi_run;
      hi_run = 0;
    end
    if (p_scl && !scl_l) sl_idx++;
    p_scl = scl_l;
    p_sda = sda_l;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic launch(input logic [7:0] c, input int idx, input logic [8:0] pat);
    @(negedge clk);
    sl_pat = pat; sl_idx = idx; mon_n = 0; irq_cnt = 0;
    wr(R_CTRL, c);
  endtask

  task automatic wait_irq();
    int t = 0;
    while (irq_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk("R3 irq pulses", irq_cnt, 1);
  endtask

  task automatic do_stop(input logic [7:0] c);
    int t = 0;
    logic [7:0] s;
    wr(R_CTRL, c);
    do begin rd(R_STAT, s); t++; end while (s[2] && t < 5000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [8:0] pat;
    int s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(R_STAT, s); chk("R1 status", s, 8'h00);
    rd(R_RXD, s);  chk("R1 rxd", s, 8'h00);
    rd(R_DIV, s);  chk("R1 div", s, 8'd4);
    chk("R1 lines", {irq, scl_oe, sda_oe}, 3'b000);

    wr(R_DIV, 8'd1);
    wr(R_CTRL, 8'h02);
    wr(R_CTRL, 8'h04);
    repeat (20) @(negedge clk);
    rd(R_STAT, s); chk("R10 idle stop/restart", s, 8'h00);
    chk("R10 no bus event", start_cnt + stop_cnt, 0);
    chk("R10 scl free", scl_oe, 1'b0);

    wr(R_MODE, 8'h00);
    wr(R_TXD, 8'hA4);
    launch(8'h01, -1, ACK_PAT);
    wait_irq();
    chk("R2 start seen", start_cnt, 1);
    chk("R2 nine clocks", mon_n, 9);
    chk("R4 address on bus", mon_sh, {8'hA4, 1'b0});
    rd(R_RXD, s);  chk("R4 readback", s, 8'hA4);
    rd(R_STAT, s); chk("R5 status ack", s, 8'h0C);
    repeat (40) @(negedge clk);
    chk("R3 scl held", scl_oe, 1'b1);
    rd(R_STAT, s); chk("R3 still parked", s, 8'h0C);

    for (int v = 0; v < 256; v++) begin
      wr(R_TXD, v[7:0]);
      launch(8'h01, 0, ACK_PAT);
      wait_irq();
      chk("R4 msb first", mon_sh, {v[7:0], 1'b0});
      rd(R_RXD, s);  chk("R4 readback", s, v[7:0]);
      rd(R_STAT, s); chk("R5 ack/err", s[1:0], 2'b00);
    end

    for (int v = 0; v < 256; v++) begin
      wr(R_MODE, {6'd0, v[0], 1'b1});
      for (int k = 0; k < 8; k++) pat[k] = ~v[7 - k];
      pat[8] = 1'b0;
      launch(8'h01, 0, pat);
      wait_irq();
      rd(R_RXD, s);  chk("R7 rx data", s, v[7:0]);
      chk("R7 bus bits and ack", mon_sh, {v[7:0], v[0]});
      rd(R_STAT, s);
      chk("R5 ack sampled", s[1], v[0]);
      chk("R6 no error in rx", s[0], 1'b0);
    end

    wr(R_MODE, 8'h00);
    wr(R_TXD, 8'h5A);
    s0 = start_cnt; p0 = stop_cnt;
    launch(8'h01, 0, ACK_PAT);
    wr(R_MODE, 8'h03);
    wr(R_CTRL, 8'h02);
    wr(R_CTRL, 8'h04);
    wait_irq();
    chk("R12 mode latched", mon_sh, {8'h5A, 1'b0});
    chk("R10 midbyte ignored", {start_cnt - s0, stop_cnt - p0}, 0);
    rd(R_STAT, s); chk("R10 still parked", s, 8'h0C);
    wr(R_MODE, 8'h00);

    wr(R_TXD, 8'h55);
    launch(8'h01, 0, 9'h000);
    wait_irq();
    rd(R_STAT, s); chk("R6 nack err", s[1:0], 2'b11);
    wr(R_STAT, 8'h00);
    rd(R_STAT, s); chk("R6 sticky", s[0], 1'b1);
    wr(R_STAT, 8'h01);
    rd(R_STAT, s); chk("R6 cleared", s[0], 1'b0);

    wr(R_TXD, 8'hFF);
    launch(8'h01, 0, 9'h104);
    wait_irq();
    rd(R_RXD, s);  chk("R6 collision readback", s, 8'hDF);
    rd(R_STAT, s); chk("R6 collision err", s[1:0], 2'b01);
    wr(R_STAT, 8'h01);

    wr(R_TXD, 8'h3C);
    s0 = start_cnt;
    launch(8'h04, -1, ACK_PAT);
    wait_irq();
    chk("R9 repeated start", start_cnt, s0 + 1);
    chk("R9 clocks", mon_n, 10);
    chk("R9 address", mon_sh, {8'h3C, 1'b0});
    rd(R_STAT, s); chk("R9 parked", s, 8'h0C);

    s0 = start_cnt; p0 = stop_cnt;
    do_stop(8'h07);
    chk("R13 stop wins", stop_cnt, p0 + 1);
    chk("R13 no start", start_cnt, s0);
    rd(R_STAT, s); chk("R8 not busy", s, 8'h00);
    chk("R8 lines free", {scl_oe, sda_oe}, 2'b00);

    launch(8'h01, -1, ACK_PAT);
    wait_irq();
    s0 = start_cnt;
    launch(8'h05, -1, ACK_PAT);
    wait_irq();
    chk("R13 restart over start", start_cnt, s0 + 1);
    chk("R13 restart clocks", mon_n, 10);
    p0 = stop_cnt;
    do_stop(8'h02);
    chk("R8 stop seen", stop_cnt, p0 + 1);
    rd(R_STAT, s); chk("R8 idle", s[2], 1'b0);

    foreach (pat[i]) if (i < 3) begin
      int d;
      d = (i == 0) ? 0 : (i == 1) ? 2 : 5;
      wr(R_DIV, d[7:0]);
      launch(8'h01, -1, ACK_PAT);
      wait_irq();
      chk("R11 scl high time", last_hi, 2 * (d + 1));
      do_stop(8'h02);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule